// File: doc/BRIEF.md
# Configurable Logic Cell with Flip-Flop Mode

This block is a small logic cell whose function is set entirely by configuration registers. Four data-select multiplexers each take one signal from a shared pool: the external inputs, the cell's own feedback, and a constant low. Four gate stages then combine the selected signals. Each gate has an enable byte that picks true or inverted terms, an OR that joins the enabled terms, and a polarity bit that can invert the result.

A mode field turns the four gate outputs into the cell result. The available functions are AND-OR, OR-XOR, four-input AND, a set-reset latch, a one-input D flip-flop with set and reset, and a two-input D flip-flop with reset. The storage modes are clocked by gate signals and not by the register clock. When inverted feedback is routed to the data gate, the cell toggles and divides its input clock by two.

Top module: `cfg_logic_cell`

## Requirements
- R1: After `rst_n` is asserted, all configuration fields are zero, and `cell_out` and `cell_fb` are both low.
- R2: A write takes effect at the rising edge of `clk` that samples `wr_en`. Address 0 is control: bit 7 is the cell enable, bit 6 the output enable, bit 4 the output polarity and bits 2:0 the mode. Addresses 1 to 4 hold the source selects of data inputs D1 to D4 in bits 2:0. Addresses 5 to 8 hold the enable bytes of gates 1 to 4. Address 9 holds the polarity bits of gates 1 to 4 in bits 0 to 3.
- R3: The pool is ext_in[5:0] at indices 0 to 5, feedback at index 6 and constant low at index 7. Data input Dk (k = 1..4) with select code c reads pool index (c + 2*(k-1)) mod 8, so one code reaches a different signal on each data input.
- R4: In a gate enable byte, bits 0 to 7 enable D1 true, D1 inverted, D2 true, D2 inverted, D3 true, D3 inverted, D4 true and D4 inverted. The gate output is the OR of the enabled terms XOR the gate's polarity bit.
- R5: An enable byte of 0x55 ORs the four true inputs and 0xAA ORs the four inverted inputs. A zero byte gives low before polarity, so the gate then outputs its polarity bit.
- R6: With two inverted terms enabled and the polarity set, a gate computes the AND of its two inputs. With two true terms and the polarity set, it computes their NOR.
- R7: Mode 0 gives (G1&G2)|(G3&G4). Mode 1 gives (G1|G2)^(G3|G4). Mode 2 gives G1&G2&G3&G4.
- R8: Mode 3 is a set-reset latch with set = G1|G2 and reset = G3|G4. Reset wins when both are active.
- R9: Mode 4 is a D flip-flop with clock G2, data G1, asynchronous reset G3 and asynchronous set G4. Reset wins over set.
- R10: Mode 5 is a D flip-flop clocked on the rising edge of G1, with data G2|G4 and asynchronous reset G3. With inverted feedback on the data path, the output toggles on each rising edge of G1 and ignores falling edges.
- R11: Modes 6 and 7 drive `cell_out` low whatever the output polarity. In the other modes, output polarity inverts the cell result.
- R12: With the cell enable clear, `cell_out` and `cell_fb` are low and the flip-flop is cleared. With the output enable clear, `cell_out` is low while the flip-flop keeps running and `cell_fb` follows it.
- R13: `cell_fb` carries the flip-flop state in modes 4 and 5 and is low in every other mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration port clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| ext_in | input | 6 | External signals offered to the data selects |
| cell_out | output | 1 | Cell output after polarity and output enable |
| cell_fb | output | 1 | Internal feedback (flip-flop state) |

## Verification
The bench targets the cases where the bit order or the source mapping could be shifted by one. It exercises the same select code on different data inputs; a design that ignored the per-input offset would route the wrong external signal and break the four-input AND. In both flip-flop modes it checks priority when reset and set or clock overlap, checks that falling edges and data-only changes leave the state alone, and checks that feedback keeps toggling while the output enable is off. A cell that gated the flip-flop with the output enable would come back out of phase. It also covers the zero-byte gate with polarity set and the unused mode codes with inverted output polarity, where a design that applied polarity after the mode decode would drive the output high.

// File: rtl/cfg_logic_cell.sv
module cfg_logic_cell #(
  parameter int EXT_W = 6,
  parameter int DW    = 8,
  parameter int AW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [EXT_W-1:0] ext_in,
  output logic             cell_out,
  output logic             cell_fb
);
  localparam int NSRC  = EXT_W + 2;
  localparam int SEL_W = $clog2(NSRC);
  localparam int NG    = 4;

  logic             en_r, oe_r, opol_r;
  logic [2:0]       mode_r;
  logic [SEL_W-1:0] sel_r [NG];
  logic [7:0]       gen_r [NG];
  logic [NG-1:0]    pol_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_r <= 1'b0; oe_r <= 1'b0; opol_r <= 1'b0; mode_r <= '0; pol_r <= '0;
      for (int k = 0; k < NG; k++) begin
        sel_r[k] <= '0;
        gen_r[k] <= '0;
      end
    end else if (wr_en) begin
      if (wr_addr == '0) begin
        en_r   <= wr_data[7];
        oe_r   <= wr_data[6];
        opol_r <= wr_data[4];
        mode_r <= wr_data[2:0];
      end
      if (wr_addr == AW'(9)) pol_r <= wr_data[NG-1:0];
      for (int k = 0; k < NG; k++) begin
        if (wr_addr == AW'(1 + k)) sel_r[k] <= wr_data[SEL_W-1:0];
        if (wr_addr == AW'(5 + k)) gen_r[k] <= wr_data;
      end
    end
  end

  logic            q;
  logic            lq;
  logic [NSRC-1:0] pool;
  logic [NG-1:0]   d, g;
  logic [7:0]      terms;

  assign pool = {1'b0, q, ext_in};

  for (genvar k = 0; k < NG; k++) begin : g_dsel
    logic [SEL_W-1:0] idx;
    assign idx  = SEL_W'((32'(sel_r[k]) + 2 * k) % NSRC);
    assign d[k] = pool[idx];
    assign terms[2*k]   = d[k];
    assign terms[2*k+1] = ~d[k];
  end

  for (genvar j = 0; j < NG; j++) begin : g_gate
    assign g[j] = (|(gen_r[j] & terms)) ^ pol_r[j];
  end

  logic is_ff, ff_clk, ff_d, ff_clr, ff_set;
  assign is_ff  = en_r && (mode_r == 3'd4 || mode_r == 3'd5);
  assign ff_clk = (mode_r == 3'd4) ? g[1] : g[0];
  assign ff_d   = (mode_r == 3'd4) ? g[0] : (g[1] | g[3]);
  assign ff_clr = !rst_n || !is_ff || g[2];
  assign ff_set = (mode_r == 3'd4) && g[3];

  always_ff @(posedge ff_clk or posedge ff_clr or posedge ff_set) begin
    if (ff_clr)      q <= 1'b0;
    else if (ff_set) q <= 1'b1;
    else             q <= ff_d;
  end

  always_latch begin
    if (!en_r || mode_r != 3'd3) lq <= 1'b0;
    else if (g[2] | g[3])        lq <= 1'b0;
    else if (g[0] | g[1])        lq <= 1'b1;
  end

  logic func, core;
  always_comb begin
    case (mode_r)
      3'd0:        func = (g[0] & g[1]) | (g[2] & g[3]);
      3'd1:        func = (g[0] | g[1]) ^ (g[2] | g[3]);
      3'd2:        func = &g;
      3'd3:        func = lq;
      3'd4, 3'd5:  func = q;
      default:     func = 1'b0;
    endcase
  end

  assign core     = en_r && (mode_r[2:1] != 2'b11) && (func ^ opol_r);
  assign cell_out = oe_r & core;
  assign cell_fb  = q;
endmodule

// File: rtl/cfg_logic_cell_chk.sv
module cfg_logic_cell_chk #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          cell_out,
  input logic          cell_fb
);
  logic ctrl_wr;
  assign ctrl_wr = wr_en && (wr_addr == '0);

  always @(posedge clk) begin
    if (!rst_n) p_reset_quiet_r1: assert (!cell_out && !cell_fb);
  end

  p_oe_off_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && !wr_data[6] |=> !cell_out);

  p_en_off_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && !wr_data[7] |=> !cell_out && !cell_fb);

  p_unused_mode_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && wr_data[2:1] == 2'b11 |=> !cell_out);

  p_fb_low_comb_r13: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && !wr_data[2] |=> !cell_fb);
endmodule

bind cfg_logic_cell cfg_logic_cell_chk #(.DW(DW), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .cell_out(cell_out), .cell_fb(cell_fb)
);

// File: tb/cfg_logic_cell_tb_top.sv
`timescale 1ns/1ps
module cfg_logic_cell_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [5:0] ext_in = '0;
  logic       cell_out, cell_fb;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cfg_logic_cell dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ext_in(ext_in), .cell_out(cell_out), .cell_fb(cell_fb)
  );

  bit    exp_q[$];
  bit    which_q[$];
  string tag_q[$];
  event  chk_ev;

  always @(chk_ev) begin
    while (exp_q.size() > 0) begin
      bit e, w, a;
      string t;
      e = exp_q.pop_front();
      w = which_q.pop_front();
      t = tag_q.pop_front();
      a = w ? cell_fb : cell_out;
      total++;
      if (a !== e) begin
        bad++;
        $display("FAIL %s (%s): actual=%0b expected=%0b", t, w ? "cell_fb" : "cell_out", a, e);
      end
    end
  end

  task automatic expect_sig(input bit w, input bit v, input string tag);
    exp_q.push_back(v);
    which_q.push_back(w);
    tag_q.push_back(tag);
    -> chk_ev;
    #0.5;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic set_ext(input logic [5:0] v);
    @(negedge clk);
    ext_in = v;
    #1;
  endtask

  task automatic setup(input logic [2:0] s1, s2, s3, s4,
                       input logic [7:0] ga, gb, gc, gd,
                       input logic [3:0] pol, input logic [7:0] ctrl);
    ext_in = '0;
    wr(4'd0, 8'h00);
    wr(4'd1, {5'd0, s1}); wr(4'd2, {5'd0, s2});
    wr(4'd3, {5'd0, s3}); wr(4'd4, {5'd0, s4});
    wr(4'd5, ga); wr(4'd6, gb); wr(4'd7, gc); wr(4'd8, gd);
    wr(4'd9, {4'd0, pol});
    wr(4'd0, ctrl);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #12 rst_n = 1'b1;
    #1;
    expect_sig(0, 0, "R1 reset out");
    expect_sig(1, 0, "R1 reset fb");
    set_ext(6'b111111);
    expect_sig(0, 0, "R1 zero config ignores inputs");

    // R2: write latency with mode 2, all gates forced high by polarity
    setup(0, 0, 0, 0, 8'h00, 8'h00, 8'h00, 8'h00, 4'hF, 8'h00);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd0; wr_data = 8'hC2;
    #1 expect_sig(0, 0, "R2 before edge");
    @(posedge clk); #1;
    expect_sig(0, 1, "R2 after edge");
    wr_en = 1'b0;

    // R3 R7: four-input AND via D1=ext0, D2=ext2, D3=ext4, D4 code3=ext1
    setup(0, 0, 0, 3, 8'h01, 8'h04, 8'h10, 8'h40, 4'h0, 8'hC2);
    set_ext(6'b010111); expect_sig(0, 1, "R7 and all high");
    set_ext(6'b010110); expect_sig(0, 0, "R7 and ext0 low");
    set_ext(6'b010101); expect_sig(0, 0, "R3 D4 code3 maps to ext1");
    set_ext(6'b000111); expect_sig(0, 0, "R3 D3 code0 maps to ext4");

    // R6: AND by inversion, mode 0 with G2 forced high
    setup(0, 0, 0, 0, 8'h0A, 8'h00, 8'h00, 8'h00, 4'h3, 8'hC0);
    set_ext(6'b000101); expect_sig(0, 1, "R6 and both high");
    set_ext(6'b000001); expect_sig(0, 0, "R6 and one low");
    set_ext(6'b000000); expect_sig(0, 0, "R6 and none");
    // R6: NOR
    setup(0, 0, 0, 0, 8'h05, 8'h00, 8'h00, 8'h00, 4'h3, 8'hC0);
    set_ext(6'b000000); expect_sig(0, 1, "R6 nor none");
    set_ext(6'b000100); expect_sig(0, 0, "R6 nor one");

    // R5 R4: 0x55, 0xAA and zero byte
    setup(0, 0, 0, 3, 8'h55, 8'h00, 8'h00, 8'h00, 4'h2, 8'hC0);
    set_ext(6'b000000); expect_sig(0, 0, "R5 0x55 none");
    set_ext(6'b000010); expect_sig(0, 1, "R5 0x55 D4 only");
    setup(0, 0, 0, 3, 8'hAA, 8'h00, 8'h00, 8'h00, 4'h2, 8'hC0);
    set_ext(6'b010111); expect_sig(0, 0, "R5 0xAA all high");
    set_ext(6'b010110); expect_sig(0, 1, "R5 0xAA one low");
    setup(0, 0, 0, 0, 8'h00, 8'h00, 8'h00, 8'h00, 4'h2, 8'hC0);
    set_ext(6'b111111); expect_sig(0, 0, "R5 zero byte low");
    setup(0, 0, 0, 0, 8'h00, 8'h00, 8'h00, 8'h00, 4'h3, 8'hC0);
    expect_sig(0, 1, "R4 polarity after OR");

    // R7: OR-XOR, then R11 output polarity
    setup(0, 0, 0, 0, 8'h01, 8'h00, 8'h10, 8'h00, 4'h0, 8'hC1);
    set_ext(6'b000001); expect_sig(0, 1, "R7 xor 10");
    set_ext(6'b010001); expect_sig(0, 0, "R7 xor 11");
    set_ext(6'b010000); expect_sig(0, 1, "R7 xor 01");
    expect_sig(1, 0, "R13 fb low in mode 1");
    wr(4'd0, 8'hD1);    expect_sig(0, 0, "R11 output polarity");

    // R11: unused modes
    setup(0, 0, 0, 0, 8'h00, 8'h00, 8'h00, 8'h00, 4'hF, 8'hC6);
    expect_sig(0, 0, "R11 mode 6 low");
    wr(4'd0, 8'hD7);    expect_sig(0, 0, "R11 mode 7 with polarity low");

    // R8: latch, set G1=ext0, reset G3=D3 code1=ext5
    setup(0, 0, 1, 0, 8'h01, 8'h00, 8'h10, 8'h00, 4'h0, 8'hC3);
    set_ext(6'b000001); expect_sig(0, 1, "R8 set");
    set_ext(6'b000000); expect_sig(0, 1, "R8 hold set");
    set_ext(6'b100000); expect_sig(0, 0, "R8 reset");
    set_ext(6'b000000); expect_sig(0, 0, "R8 hold reset");
    set_ext(6'b100001); expect_sig(0, 0, "R8 reset wins");

    // R10: divide by two, clock G1=ext0, D=G2=~fb (D2 code4), reset G3=ext5
    setup(0, 4, 1, 0, 8'h01, 8'h08, 8'h10, 8'h00, 4'h0, 8'hC5);
    expect_sig(0, 0, "R10 start");
    set_ext(6'b000001); expect_sig(0, 1, "R10 toggle 1");
    set_ext(6'b000000); expect_sig(0, 1, "R10 falling edge ignored");
    set_ext(6'b000001); expect_sig(0, 0, "R10 toggle 2");
    set_ext(6'b000000);
    set_ext(6'b000001); expect_sig(0, 1, "R10 toggle 3");
    expect_sig(1, 1, "R13 fb follows flop");
    set_ext(6'b000000);
    wr(4'd0, 8'h85);    expect_sig(0, 0, "R12 oe off pin low");
    expect_sig(1, 1, "R12 fb kept with oe off");
    set_ext(6'b000001); expect_sig(1, 0, "R12 flop runs with oe off");
    expect_sig(0, 0, "R12 pin still low");
    set_ext(6'b000000);
    wr(4'd0, 8'hC5);    expect_sig(0, 0, "R12 oe back, state kept");
    set_ext(6'b000001); expect_sig(0, 1, "R10 toggle 4");
    set_ext(6'b100001); expect_sig(0, 0, "R10 async reset");
    set_ext(6'b100000);
    set_ext(6'b100001); expect_sig(0, 0, "R10 clock blocked in reset");
    set_ext(6'b000000); expect_sig(0, 0, "R10 reset released");
    set_ext(6'b000001); expect_sig(0, 1, "R10 toggle after reset");
    wr(4'd0, 8'hD5);    expect_sig(0, 0, "R11 polarity on flop");
    wr(4'd0, 8'h45);    expect_sig(0, 0, "R12 disabled out");
    expect_sig(1, 0, "R12 disabled clears flop");
    wr(4'd0, 8'hC5);    expect_sig(0, 0, "R12 flop stays cleared");

    // R9: data G1=ext1, clock G2=ext2, reset G3=ext5, set G4=D4 code6=ext4
    setup(1, 0, 1, 6, 8'h01, 8'h04, 8'h10, 8'h40, 4'h0, 8'hC4);
    set_ext(6'b000010); expect_sig(0, 0, "R9 data without clock");
    set_ext(6'b000110); expect_sig(0, 1, "R9 capture 1");
    set_ext(6'b000000); expect_sig(0, 1, "R9 hold");
    set_ext(6'b000100); expect_sig(0, 0, "R9 capture 0");
    set_ext(6'b000000);
    set_ext(6'b010000); expect_sig(0, 1, "R9 async set");
    set_ext(6'b000000); expect_sig(0, 1, "R9 hold after set");
    set_ext(6'b100000); expect_sig(0, 0, "R9 async reset");
    set_ext(6'b110000); expect_sig(0, 0, "R9 reset wins over set");
    set_ext(6'b000000);
    wr(4'd0, 8'hC0);    expect_sig(1, 0, "R13 fb low in mode 0");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule